// File: doc/BRIEF.md
# Link Negotiation Arbiter with Parallel Detection and Restart

This block is the decision-making state machine behind 10/100 Ethernet link negotiation. It watches four abstract indications from the receive side: a valid-link flag from the 10 Mb/s receiver, a valid-link flag from the 100 Mb/s receiver, a flag that negotiation pulse bursts arrive from the partner, and a flag that a base page exchange has just finished. It also sees the enable and restart bits of the management control register, and a pulse that marks a read of the expansion status register.

When the partner negotiates, the finished page exchange sets the result. When the partner only sends plain link signalling, the block settles the mode by parallel detection. A partner that looks valid on both receivers at once is recorded as a parallel-detect fault. Every renegotiation request first holds the transmitter silent for a long break-link period. Only after that does the negotiation phase begin. Negotiation is armed only by a clear-then-set edge on the enable bit, so a device that leaves reset with the bit already set stays in forced mode. A link lost after completion sends the block back to listening, without a break period.

Top module: `an_pd_arbiter`

## Requirements
- R1: After reset, `an_complete`, `tx_silence` and `speed_100` are 0, and `lp_ability` and `exp_status` are all zero.
- R2: Negotiation becomes active only on a 0-to-1 edge of `cfg_an_en`. An enable held at 1 from reset onward starts nothing. While `cfg_an_en` is 0, `an_complete` and `tx_silence` are 0 from the next cycle on.
- R3: An enable edge or an accepted restart raises `tx_silence` in the next cycle. It then stays high for exactly BREAK_CYC cycles and falls as the listening phase begins.
- R4: A `cfg_restart` pulse while negotiation is active, in any phase including after completion, clears completion and the partner fields and starts a new break period. A restart pulse while negotiation is inactive is ignored.
- R5: In the listening phase, a 10 Mb/s link alone with no partner pulses completes by parallel detection. The result is `lp_ability` = 0x0021 (bit 5 set, selector bits 4:0 = 00001), `speed_100` = 0, and `exp_status[0]` (partner negotiation-able) = 0 while `an_complete` = 1. While partner pulses are seen, a single link does not complete.
- R6: A 100 Mb/s link alone with no partner pulses completes with `lp_ability` = 0x0081 (bit 7 set, selector 00001) and `speed_100` = 1.
- R7: Both links valid with no partner pulses in the listening phase sets `exp_status[4]` (parallel-detect fault). This does not complete negotiation. The bit stays set until a `status_rd` pulse clears it. When a set and a read fall in the same cycle, the set wins.
- R8: `page_done` takes priority over a parallel-detect condition. It loads `page_word` into `lp_ability` and sets `exp_status[0]` and `exp_status[1]` (page received). It copies `page_word[15]` into `exp_status[3]` (partner next page). `speed_100` = `page_word[7] | page_word[8]`. `exp_status[2]` always shows the LOCAL_NP parameter.
- R9: After completion, loss of the link for the resolved speed clears `an_complete` and returns to listening with `tx_silence` low. A returning link completes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_an_en | input | 1 | Negotiation enable bit of the control register |
| cfg_restart | input | 1 | One-cycle pulse: restart bit written with 1 |
| status_rd | input | 1 | One-cycle pulse: expansion status register read |
| link10_ok | input | 1 | 10 Mb/s receiver reports a valid link |
| link100_ok | input | 1 | 100 Mb/s receiver reports a valid link |
| flp_seen | input | 1 | Partner negotiation pulse bursts are being received |
| page_done | input | 1 | Base page exchange finished this cycle |
| page_word | input | 16 | Partner base page received by the exchange |
| lp_ability | output | 16 | Partner ability field |
| exp_status | output | 5 | {pd fault, partner next page, local next page, page received, partner negotiation-able} |
| an_complete | output | 1 | Negotiation complete |
| speed_100 | output | 1 | Resolved speed: 1 = 100 Mb/s, 0 = 10 Mb/s |
| tx_silence | output | 1 | Hold off all transmit data and link pulses |

## Verification
Two pairs of events can fall in one clock. The first pair is the sticky fault being set and the status read that clears it. The bench holds both receivers valid while it pulses `status_rd`, and expects the fault bit to read 1 afterwards. A separate read with the links idle must clear the bit. The second pair is a finished page exchange and a valid single-link parallel-detect condition. The bench raises both in one cycle and judges the result by `lp_ability`, `speed_100` and `exp_status`: the page contents and the negotiation-able bit must win over the 0x0021 parallel-detect pattern.

// File: rtl/an_pd_pkg.sv
package an_pd_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_BREAK  = 2'd1,
        ST_LISTEN = 2'd2,
        ST_DONE   = 2'd3
    } an_state_e;

    localparam int ABIL_W     = 16;
    localparam int POS_10     = 5;
    localparam int POS_100    = 7;
    localparam int POS_100FD  = 8;
    localparam int POS_NP     = 15;
    localparam logic [4:0] SEL_ETH = 5'b00001;

    typedef struct packed {
        an_state_e          st;
        logic [ABIL_W-1:0]  lp_abil;
        logic               lp_an_able;
        logic               pg_rcvd;
        logic               lp_np;
        logic               pd_fault;
        logic               done;
        logic               spd100;
    } an_regs_t;

endpackage

// File: rtl/an_en_edge.sv
module an_en_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic rise
);
    logic en_d, en_q;

    always_comb begin
        en_d = en;
        rise = en & ~en_q;
    end

    // Resets to 1 so an enable already high out of reset is no edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_d;
    end
endmodule

// File: rtl/an_break_timer.sv
module an_break_timer #(
    parameter int BREAK_CYC = 75_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int CNT_W = $clog2(BREAK_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BREAK_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        expire = (cnt_q == CNT_W'(1)) && !start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/an_pd_classify.sv
module an_pd_classify (
    input  logic link10,
    input  logic link100,
    input  logic flp,
    output logic only10,
    output logic only100,
    output logic clash
);
    always_comb begin
        only10  = !flp &&  link10 && !link100;
        only100 = !flp && !link10 &&  link100;
        clash   = !flp &&  link10 &&  link100;
    end
endmodule

// File: rtl/an_pd_arbiter.sv
module an_pd_arbiter
    import an_pd_pkg::*;
#(
    parameter int   BREAK_CYC = 75_000_000,
    parameter logic LOCAL_NP  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_an_en,
    input  logic              cfg_restart,
    input  logic              status_rd,
    input  logic              link10_ok,
    input  logic              link100_ok,
    input  logic              flp_seen,
    input  logic              page_done,
    input  logic [15:0]       page_word,
    output logic [15:0]       lp_ability,
    output logic [4:0]        exp_status,
    output logic              an_complete,
    output logic              speed_100,
    output logic              tx_silence
);
    an_regs_t r_d, r_q;
    logic en_rise, brk_start, brk_expire;
    logic only10, only100, clash;
    logic armed, fault_set;

    an_en_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_an_en),
        .rise  (en_rise)
    );

    an_break_timer #(.BREAK_CYC(BREAK_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (brk_start),
        .expire (brk_expire)
    );

    an_pd_classify u_cls (
        .link10  (link10_ok),
        .link100 (link100_ok),
        .flp     (flp_seen),
        .only10  (only10),
        .only100 (only100),
        .clash   (clash)
    );

    assign armed = (r_q.st != ST_OFF);

    always_comb begin
        r_d       = r_q;
        brk_start = 1'b0;
        fault_set = 1'b0;

        if (!cfg_an_en) begin
            r_d.st   = ST_OFF;
            r_d.done = 1'b0;
        end else if (en_rise || (cfg_restart && armed)) begin
            brk_start      = 1'b1;
            r_d.st         = ST_BREAK;
            r_d.lp_abil    = '0;
            r_d.lp_an_able = 1'b0;
            r_d.pg_rcvd    = 1'b0;
            r_d.lp_np      = 1'b0;
            r_d.done       = 1'b0;
            r_d.spd100     = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_BREAK: begin
                    if (brk_expire) r_d.st = ST_LISTEN;
                end
                ST_LISTEN: begin
                    if (page_done) begin
                        r_d.st         = ST_DONE;
                        r_d.done       = 1'b1;
                        r_d.lp_abil    = page_word;
                        r_d.lp_an_able = 1'b1;
                        r_d.pg_rcvd    = 1'b1;
                        r_d.lp_np      = page_word[POS_NP];
                        r_d.spd100     = page_word[POS_100] | page_word[POS_100FD];
                    end else if (only10 || only100) begin
                        r_d.st                = ST_DONE;
                        r_d.done              = 1'b1;
                        r_d.lp_abil           = '0;
                        r_d.lp_abil[4:0]      = SEL_ETH;
                        r_d.lp_abil[POS_10]   = only10;
                        r_d.lp_abil[POS_100]  = only100;
                        r_d.lp_an_able        = 1'b0;
                        r_d.pg_rcvd           = 1'b0;
                        r_d.lp_np             = 1'b0;
                        r_d.spd100            = only100;
                    end else if (clash) begin
                        fault_set = 1'b1;
                    end
                end
                ST_DONE: begin
                    if (r_q.spd100 ? !link100_ok : !link10_ok) begin
                        r_d.st   = ST_LISTEN;
                        r_d.done = 1'b0;
                    end
                end
                default: r_d.st = ST_OFF;
            endcase
        end

        // Read clears the sticky fault; a new fault in the same cycle wins.
        if (status_rd) r_d.pd_fault = 1'b0;
        if (fault_set) r_d.pd_fault = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_OFF, lp_abil: '0, lp_an_able: 1'b0, pg_rcvd: 1'b0,
                     lp_np: 1'b0, pd_fault: 1'b0, done: 1'b0, spd100: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign lp_ability  = r_q.lp_abil;
    assign exp_status  = {r_q.pd_fault, r_q.lp_np, LOCAL_NP, r_q.pg_rcvd, r_q.lp_an_able};
    assign an_complete = r_q.done;
    assign speed_100   = r_q.spd100;
    assign tx_silence  = (r_q.st == ST_BREAK);

endmodule

// File: rtl/an_pd_checker.sv
module an_pd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_an_en,
    input logic        cfg_restart,
    input logic        status_rd,
    input logic        armed,
    input logic [15:0] lp_ability,
    input logic [4:0]  exp_status,
    input logic        an_complete,
    input logic        speed_100,
    input logic        tx_silence
);
    p_silence_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_silence |-> !an_complete)
        else $error("R3: silence while complete");

    p_restart_breaks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_restart && cfg_an_en && armed) |=> (tx_silence && !an_complete))
        else $error("R4: accepted restart did not start a break");

    p_disable_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_an_en |=> (!tx_silence && !an_complete))
        else $error("R2: activity while disabled");

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_status[4] && !status_rd) |=> exp_status[4])
        else $error("R7: fault cleared without read");

    p_pd_not_able_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (an_complete && !exp_status[1]) |-> (!exp_status[0] && lp_ability[4:0] == 5'b00001))
        else $error("R5: parallel-detect result fields wrong");

    p_pd_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (an_complete && !exp_status[1]) |->
            ($countones({lp_ability[7], lp_ability[5]}) == 1 && speed_100 == lp_ability[7]))
        else $error("R6: parallel-detect technology bits wrong");
endmodule

bind an_pd_arbiter an_pd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_an_en   (cfg_an_en),
    .cfg_restart (cfg_restart),
    .status_rd   (status_rd),
    .armed       (armed),
    .lp_ability  (lp_ability),
    .exp_status  (exp_status),
    .an_complete (an_complete),
    .speed_100   (speed_100),
    .tx_silence  (tx_silence)
);

// File: tb/sim_an_pd_arbiter.sv
`timescale 1ns/1ps
module sim_an_pd_arbiter;
    localparam int BRK = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_an_en = 1'b1, cfg_restart = 1'b0, status_rd = 1'b0;
    logic        link10_ok = 1'b0, link100_ok = 1'b0, flp_seen = 1'b0, page_done = 1'b0;
    logic [15:0] page_word = '0;
    logic [15:0] lp_ability;
    logic [4:0]  exp_status;
    logic        an_complete, speed_100, tx_silence;

    an_pd_arbiter #(.BREAK_CYC(BRK), .LOCAL_NP(1'b0)) u0 (
        .clk, .rst_n, .cfg_an_en, .cfg_restart, .status_rd,
        .link10_ok, .link100_ok, .flp_seen, .page_done, .page_word,
        .lp_ability, .exp_status, .an_complete, .speed_100, .tx_silence
    );

    always #10 clk = ~clk;

    typedef struct {
        string       req;
        int          sel;
        logic [15:0] val;
    } item_t;

    item_t q[$];
    int vectors = 0;
    int errs = 0;
    int cycles = 0;
    bit done = 0;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_out(string req, int sel, logic [15:0] val);
        item_t it;
        it.req = req; it.sel = sel; it.val = val;
        q.push_back(it);
    endtask

    function automatic logic [15:0] pick(int sel);
        case (sel)
            0: return {15'd0, an_complete};
            1: return {15'd0, tx_silence};
            2: return lp_ability;
            3: return {11'd0, exp_status};
            default: return {15'd0, speed_100};
        endcase
    endfunction

    // Monitor: compare queued expectations half a cycle after each edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            act = pick(it.sel);
            vectors++;
            if (act !== it.val) begin
                errs++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.val);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errs++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    task automatic break_wait(string req);
        for (int i = 0; i < BRK - 1; i++) tick();
        expect_out(req, 1, 16'd1);
        tick();
        expect_out(req, 1, 16'd0);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // r1_ reset state
        expect_out("R1", 0, 16'd0);
        expect_out("R1", 1, 16'd0);
        expect_out("R1", 2, 16'd0);
        expect_out("R1", 3, 16'd0);
        expect_out("R1", 4, 16'd0);

        // R2: enable high since reset, valid link: nothing happens
        link10_ok = 1'b1;
        for (int i = 0; i < 20; i++) tick();
        expect_out("R2", 0, 16'd0);
        expect_out("R2", 1, 16'd0);
        // R4: restart while inactive is ignored
        cfg_restart = 1'b1; tick(); cfg_restart = 1'b0;
        expect_out("R4", 1, 16'd0);
        tick();
        expect_out("R4", 0, 16'd0);

        // R3: clear-then-set edge starts a break of BRK cycles
        link10_ok = 1'b0;
        cfg_an_en = 1'b0; tick();
        cfg_an_en = 1'b1; tick();
        expect_out("R3", 1, 16'd1);
        break_wait("R3");
        expect_out("R3", 0, 16'd0);

        // R5: single 10 link, pulses present -> no completion
        link10_ok = 1'b1; flp_seen = 1'b1; tick();
        expect_out("R5", 0, 16'd0);
        flp_seen = 1'b0; tick();
        expect_out("R5", 0, 16'd1);
        expect_out("R5", 2, 16'h0021);
        expect_out("R5", 4, 16'd0);
        expect_out("R5", 3, 16'h0000);

        // R9: link loss returns to listening, no silence
        link10_ok = 1'b0; tick();
        expect_out("R9", 0, 16'd0);
        expect_out("R9", 1, 16'd0);
        link10_ok = 1'b1; tick();
        expect_out("R9", 0, 16'd1);

        // R4: restart from completion, then R6 on 100 link
        cfg_restart = 1'b1; tick(); cfg_restart = 1'b0;
        expect_out("R4", 1, 16'd1);
        expect_out("R4", 0, 16'd0);
        expect_out("R4", 2, 16'h0000);
        link10_ok = 1'b0; link100_ok = 1'b1;
        break_wait("R4");
        tick();
        expect_out("R6", 0, 16'd1);
        expect_out("R6", 2, 16'h0081);
        expect_out("R6", 4, 16'd1);

        // R7: both links valid -> sticky fault, no completion
        cfg_restart = 1'b1; link10_ok = 1'b1; tick(); cfg_restart = 1'b0;
        break_wait("R7");
        tick();
        expect_out("R7", 3, 16'h0010);
        expect_out("R7", 0, 16'd0);
        link10_ok = 1'b0; link100_ok = 1'b0; tick();
        expect_out("R7", 3, 16'h0010);
        status_rd = 1'b1; tick(); status_rd = 1'b0;
        expect_out("R7", 3, 16'h0000);
        // same-cycle set and read: set wins
        link10_ok = 1'b1; link100_ok = 1'b1; status_rd = 1'b1; tick();
        status_rd = 1'b0; link10_ok = 1'b0; link100_ok = 1'b0;
        expect_out("R7", 3, 16'h0010);
        status_rd = 1'b1; tick(); status_rd = 1'b0;
        expect_out("R7", 3, 16'h0000);

        // R8: page exchange wins over parallel-detect condition
        link10_ok = 1'b1; page_done = 1'b1; page_word = 16'h8081; tick();
        page_done = 1'b0;
        expect_out("R8", 0, 16'd1);
        expect_out("R8", 2, 16'h8081);
        expect_out("R8", 4, 16'd1);
        expect_out("R8", 3, 16'h000B);

        // R2: dropping enable clears completion and silence
        cfg_an_en = 1'b0; tick();
        expect_out("R2", 0, 16'd0);
        expect_out("R2", 1, 16'd0);

        tick(); tick();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule